// File: doc/BRIEF.md
# Command/Response Ready Flag and Dual-Vector Interrupt Logic

This block is the host-side register and interrupt front end of a communications coprocessor. The host reads and writes three byte-wide registers: two control bytes and one status byte. Each write is a plain write, a bit-set or a bit-clear, and it changes only the bits it names. When the host wants to hand the coprocessor a command, it sets a command-request bit. The block answers by raising an input-ready flag, and that flag drives interrupt vector A. When the device side has a result for the host, it pulses a strobe. The block then raises an output-ready flag, which drives interrupt vector B.

The two ready flags are never set at the same time, and a pending command request wins over a pending result. The host finishes a transfer by clearing the ready flag it was handling. Clearing the flag also withdraws that vector's interrupt in the same cycle, so a stale request cannot reach the wrong handler. Each vector has its own pending latch. An acknowledge input for a vector clears only that vector's latch. A force bit and a step bit in the upper control byte together produce a one-cycle execute pulse toward the core, and the step bit then clears itself.

Top module: `hsk_irq_ctl`

## Requirements
- R1: After reset every register bit, both ready flags, both interrupt outputs and the execute pulse are 0.
- R2: host_rdata combinationally shows the byte at host_addr. Address 0 holds enable-A (bit 0), enable-B (bit 2) and command request (bit 7). Address 1 holds step (bit 0), force (bit 1) and run (bit 7). Address 2 holds input-ready (bit 4) and output-ready (bit 7). Every other bit, and address 3, reads 0.
- R3: A write with host_op 0 loads host_wdata, op 1 sets the bits that are 1 in host_wdata, op 2 clears the bits that are 1 in host_wdata, and op 3 changes nothing. Bits of the byte that the operation does not name keep their value.
- R4: Input-ready is set at the clock edge after one in which command request and run are 1 and both ready flags are 0. Only the host can clear it, and no host write can set either ready flag.
- R5: Output-ready is set at an edge where a device result is held, run is 1, both flags are 0 and the input-ready condition of R4 is false. The two flags are never 1 together.
- R6: irq_a goes high on the same edge that sets input-ready, if enable-A was 1 before that edge. irq_b behaves the same way for output-ready and enable-B. An enable that is 0 at that edge produces no interrupt for that event.
- R7: A host write that leaves a ready flag at 0 also drops that vector's interrupt on the same edge.
- R8: iack_a clears only irq_a and iack_b clears only irq_b, effective at the next edge.
- R9: Once command request is 0, input-ready is not set again.
- R10: While step and force are both 1, exec_step is 1. At the next edge without a host write to address 1, step clears itself, so one request gives a single-cycle pulse.
- R11: A dev_out_req pulse is held in a one-entry slot until output-ready is set from it. A pulse that arrives in the same cycle as that set refills the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_op | input | 2 | 0 write, 1 bit-set, 2 bit-clear, 3 no-op |
| host_addr | input | 2 | Byte select for write and read |
| host_wdata | input | 8 | Host write data or bit mask |
| host_rdata | output | 8 | Selected byte |
| dev_out_req | input | 1 | Device-side result-ready strobe |
| iack_a | input | 1 | Acknowledge for vector A |
| iack_b | input | 1 | Acknowledge for vector B |
| irq_a | output | 1 | Vector A interrupt request |
| irq_b | output | 1 | Vector B interrupt request |
| ready_in | output | 1 | Input-ready flag |
| ready_out | output | 1 | Output-ready flag |
| exec_step | output | 1 | Single-cycle execute request |

## Verification
The timing the checks rely on is as follows. A control write takes effect at its own edge, and host_rdata shows it in the same cycle. Input-ready and irq_a appear one edge after that, because the request bit is registered first. The same one-edge delay applies to a device strobe and output-ready, provided the flags are free. A host clear of a ready flag, and an acknowledge, remove the interrupt at the edge that samples them. The bench drives inputs on the falling edge. It advances its behavioural model on the rising edge and compares every output one nanosecond later. The directed checks wait exactly the number of edges listed above before they sample.

// File: rtl/hsk_irq_ctl.sv
module hsk_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [1:0] host_op,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       dev_out_req,
  input  logic       iack_a,
  input  logic       iack_b,
  output logic       irq_a,
  output logic       irq_b,
  output logic       ready_in,
  output logic       ready_out,
  output logic       exec_step
);
  localparam logic [7:0] CTL0_MASK = 8'h85;
  localparam logic [7:0] CTL1_MASK = 8'h83;
  localparam int IEA = 0, IEB = 2, RQI = 7;
  localparam int STP = 0, FRC = 1, RUN = 7;
  localparam int RDI = 4, RDO = 7;

  logic [7:0] ctl0_q, ctl1_q;
  logic rdyi_q, rdyo_q, opend_q, pend_a_q, pend_b_q;

  function automatic logic [7:0] byte_op(input logic [1:0] op, input logic [7:0] cur,
                                         input logic [7:0] wd);
    case (op)
      2'd0:    byte_op = wd;
      2'd1:    byte_op = cur | wd;
      2'd2:    byte_op = cur & ~wd;
      default: byte_op = cur;
    endcase
  endfunction

  wire wr0 = host_we && host_addr == 2'd0;
  wire wr1 = host_we && host_addr == 2'd1;
  wire wr2 = host_we && host_addr == 2'd2;
  wire run = ctl1_q[RUN];

  wire [7:0] sts = {rdyo_q, 2'b00, rdyi_q, 4'b0000};
  wire [7:0] sts_wr = byte_op(host_op, sts, host_wdata);
  wire clr_ri = wr2 && !sts_wr[RDI];
  wire clr_ro = wr2 && !sts_wr[RDO];

  wire idle  = !rdyi_q && !rdyo_q;
  wire set_ri = ctl0_q[RQI] && run && idle;
  wire set_ro = opend_q && run && idle && !set_ri;

  assign exec_step = ctl1_q[STP] && ctl1_q[FRC];
  assign ready_in  = rdyi_q;
  assign ready_out = rdyo_q;
  assign irq_a     = pend_a_q;
  assign irq_b     = pend_b_q;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = ctl0_q;
      2'd1:    host_rdata = ctl1_q;
      2'd2:    host_rdata = sts;
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0_q   <= '0;
      ctl1_q   <= '0;
      rdyi_q   <= 1'b0;
      rdyo_q   <= 1'b0;
      opend_q  <= 1'b0;
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      if (wr0) ctl0_q <= byte_op(host_op, ctl0_q, host_wdata) & CTL0_MASK;
      if (wr1) ctl1_q <= byte_op(host_op, ctl1_q, host_wdata) & CTL1_MASK;
      else if (exec_step) ctl1_q[STP] <= 1'b0;

      if (set_ri) rdyi_q <= 1'b1;
      else if (clr_ri) rdyi_q <= 1'b0;
      if (set_ro) rdyo_q <= 1'b1;
      else if (clr_ro) rdyo_q <= 1'b0;

      if (dev_out_req) opend_q <= 1'b1;
      else if (set_ro) opend_q <= 1'b0;

      if (set_ri && ctl0_q[IEA]) pend_a_q <= 1'b1;
      else if (clr_ri || iack_a) pend_a_q <= 1'b0;
      if (set_ro && ctl0_q[IEB]) pend_b_q <= 1'b1;
      else if (clr_ro || iack_b) pend_b_q <= 1'b0;
    end
  end
endmodule

module hsk_irq_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic rdyi,
  input logic rdyo,
  input logic rqi,
  input logic run,
  input logic ie_a,
  input logic wr1,
  input logic irq_a,
  input logic irq_b,
  input logic iack_a,
  input logic iack_b,
  input logic exec_step
);
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rdyi && rdyo)); // R5
  AST_IRQ_A_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_a |-> rdyi); // R7
  AST_IRQ_B_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_b |-> rdyo); // R7
  AST_RDYI_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdyi) |-> $past(rqi && run)); // R4
  AST_IRQ_A_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_a) |-> $past(ie_a && run)); // R6
  AST_ACK_A_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (iack_a && rdyi) |=> !irq_a); // R8
  AST_ACK_B_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (iack_b && rdyo) |=> !irq_b); // R8
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (exec_step && !wr1) |=> !exec_step); // R10
endmodule

bind hsk_irq_ctl hsk_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdyi(rdyi_q), .rdyo(rdyo_q), .rqi(ctl0_q[7]), .run(ctl1_q[7]),
  .ie_a(ctl0_q[0]), .wr1(wr1), .irq_a(irq_a), .irq_b(irq_b), .iack_a(iack_a),
  .iack_b(iack_b), .exec_step(exec_step)
);

// File: tb/tb_hsk_irq_ctl.sv
`timescale 1ns/1ps
module tb_hsk_irq_ctl;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, dev_out_req = 0, iack_a = 0, iack_b = 0;
  logic [1:0] host_op = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq_a, irq_b, ready_in, ready_out, exec_step;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hsk_irq_ctl dut (.*);

  bit m_iea, m_ieb, m_rqi, m_step, m_force, m_run, m_ri, m_ro, m_slot, m_pa, m_pb;

  function automatic logic [7:0] mop(input int op, input logic [7:0] cur, input logic [7:0] wd);
    if (op == 0) return wd;
    if (op == 1) return cur | wd;
    if (op == 2) return cur & ~wd;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_iea, m_ieb, m_rqi, m_step, m_force, m_run, m_ri, m_ro, m_slot, m_pa, m_pb} = '0;
    end else begin
      bit wi, wo, ex, oiea, oieb, cri, cro;
      logic [7:0] nv;
      wi = m_rqi && m_run && !m_ri && !m_ro;
      wo = m_slot && m_run && !m_ri && !m_ro && !wi;
      ex = m_step && m_force;
      oiea = m_iea; oieb = m_ieb;
      cri = 0; cro = 0;
      if (host_we && host_addr == 0) begin
        nv = mop(host_op, {m_rqi, 4'b0, m_ieb, 1'b0, m_iea}, host_wdata);
        m_rqi = nv[7]; m_ieb = nv[2]; m_iea = nv[0];
      end
      if (host_we && host_addr == 1) begin
        nv = mop(host_op, {m_run, 5'b0, m_force, m_step}, host_wdata);
        m_run = nv[7]; m_force = nv[1]; m_step = nv[0];
      end else if (ex) m_step = 0;
      if (host_we && host_addr == 2) begin
        cri = (host_op == 0 && !host_wdata[4]) || (host_op == 2 && host_wdata[4]);
        cro = (host_op == 0 && !host_wdata[7]) || (host_op == 2 && host_wdata[7]);
      end
      if (wi) m_ri = 1; else if (cri) m_ri = 0;
      if (wo) m_ro = 1; else if (cro) m_ro = 0;
      if (dev_out_req) m_slot = 1; else if (wo) m_slot = 0;
      if (wi && oiea) m_pa = 1; else if (cri || iack_a) m_pa = 0;
      if (wo && oieb) m_pb = 1; else if (cro || iack_b) m_pb = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: return {m_rqi, 4'b0, m_ieb, 1'b0, m_iea};
      2'd1: return {m_run, 5'b0, m_force, m_step};
      2'd2: return {m_ro, 2'b0, m_ri, 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk("R4 ready_in", ready_in, m_ri);
      chk("R5 ready_out", ready_out, m_ro);
      chk("R6 irq_a", irq_a, m_pa);
      chk("R6 irq_b", irq_b, m_pb);
      chk("R10 exec_step", exec_step, m_step && m_force);
      chk("R2 host_rdata", host_rdata, m_rd(host_addr));
    end
  end

  task automatic hw(input logic [1:0] a, input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_op = op; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    after_edge();
    chk("R1 irq_a reset", irq_a, 0);
    chk("R1 ready_in reset", ready_in, 0);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); host_addr = a[1:0]; #1;
      chk("R1 R2 byte reset", host_rdata, 0);
    end

    hw(2'd1, 2'd1, 8'h80);
    hw(2'd0, 2'd0, 8'hff);
    #1 chk("R2 ctl0 masked", host_rdata, 8'h85);
    chk("R4 one edge latency", ready_in, 0);
    after_edge();
    chk("R4 ready_in set", ready_in, 1);
    chk("R6 irq_a raised", irq_a, 1);

    pulse(dev_out_req);
    after_edge();
    chk("R5 no output while input", ready_out, 0);
    pulse(iack_a);
    chk("R8 iack_a clears", irq_a, 0);
    chk("R8 flag stays", ready_in, 1);

    hw(2'd2, 2'd1, 8'h90);
    host_addr = 2'd2; #1;
    chk("R3 R4 set op cannot set flag", host_rdata, 8'h10);

    hw(2'd0, 2'd2, 8'h80);
    hw(2'd2, 2'd2, 8'h10);
    chk("R7 flag cleared", ready_in, 0);
    after_edge();
    chk("R9 no new ready_in", ready_in, 0);
    chk("R11 held result served", ready_out, 1);
    chk("R6 irq_b raised", irq_b, 1);

    pulse(iack_a);
    chk("R8 iack_a spares irq_b", irq_b, 1);
    hw(2'd2, 2'd0, 8'h00);
    chk("R7 write clears ready_out", ready_out, 0);
    chk("R7 irq_b withdrawn", irq_b, 0);

    hw(2'd1, 2'd1, 8'h02);
    chk("R10 force alone", exec_step, 0);
    hw(2'd1, 2'd1, 8'h01);
    chk("R10 pulse", exec_step, 1);
    after_edge();
    chk("R10 single cycle", exec_step, 0);
    host_addr = 2'd1; #1;
    chk("R3 R10 step self-clear", host_rdata, 8'h82);

    hw(2'd0, 2'd0, 8'h80);
    after_edge();
    chk("R6 disabled no irq", irq_a, 0);
    chk("R4 flag without enable", ready_in, 1);
    hw(2'd2, 2'd3, 8'h00);
    chk("R3 no-op keeps flag", ready_in, 1);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      host_we = ($urandom_range(0, 9) < 3);
      host_addr = $urandom_range(0, 3);
      host_op = $urandom_range(0, 3);
      host_wdata = $urandom;
      if (host_addr == 1 && $urandom_range(0, 3) != 0) host_wdata[7] = 1;
      dev_out_req = ($urandom_range(0, 9) < 2);
      iack_a = ($urandom_range(0, 9) == 0);
      iack_b = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk);
    host_we = 0; dev_out_req = 0; iack_a = 0; iack_b = 0;
    after_edge();
    finish_run();
  end
endmodule